// File: doc/BRIEF.md
# Programmable Baud Clock Divider

This block is a single baud-clock source for serial channels. A system normally carries several identical copies, and a channel can take its clock from any of them. Each copy divides the internal clock to make two outputs. The first is a one-cycle clock-enable tick. The second is a square wave with 50% duty cycle that changes level on every tick.

A single 32-bit configuration word controls the block, and it is written and read through a plain port. The word has three fields:

- a run bit that starts the divider;
- a 12-bit reload value equal to the divisor minus one;
- a prescale select that adds a divide-by-16 stage ahead of the 12-bit counter.

The prescaler lets the block reach slow rates that the 12-bit counter cannot reach alone. Every write restarts the divider from the newly written settings.

Top module: `baud_div_top`

## Requirements
- R1: After reset, `cfg_rdata` is 0, `tick_o` is 0 and `baud_o` is 0.
- R2: `cfg_rdata` returns the last written word masked to the defined fields. These are bit 16 (run), bits 12:1 (reload) and bit 0 (prescale). Every other bit reads as 0.
- R3: With run set and prescale clear, a reload value N gives a tick period of N+1 cycles. The first tick comes in the (N+1)-th cycle after the write.
- R4: While run is clear, `tick_o` and `baud_o` stay 0 and no tick is produced.
- R5: With run and prescale both set, a reload value N gives a tick period of 16*(N+1) cycles. The first tick comes 16*(N+1) cycles after the write.
- R6: A reload value of 0 gives a tick on every cycle when prescale is clear, and a tick every 16 cycles when prescale is set.
- R7: The largest reload value, 4095, gives a tick period of 4096 cycles when prescale is clear.
- R8: `baud_o` is 0 after every write and inverts in the cycle after each tick.
- R9: A write restarts both the prescale stage and the counter from the new word, even while the block is running. This holds when a tick falls in the same cycle as the write, and in that case the restart wins.
- R10: When the reload value is non-zero, each tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word, masked |
| tick_o | output | 1 | One-cycle clock-enable tick |
| baud_o | output | 1 | Square baud clock, toggles per tick |

## Verification
A write takes effect at the clock edge that samples it. `cfg_rdata` shows the new word in the very next cycle. The first tick is due N+1 cycles after the write edge without prescale, and 16*(N+1) cycles after it with prescale. `baud_o` changes level one cycle after the tick that causes it.

The bench keeps its own count of cycles since the last write and its own count of ticks. From these it derives, each cycle, whether a tick is due and which level the square wave should have. It compares all three outputs at the falling edge of every clock, so every one of these latencies is checked in the exact cycle it is due.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

  // Bit positions of the configuration word; neighbours decode these.
  localparam int unsigned PRESCALE_BIT = 0;
  localparam int unsigned RELOAD_LSB   = 1;
  localparam int unsigned RUN_BIT      = 16;

  // Mask of the defined configuration bits for a given reload width.
  function automatic logic [31:0] cfg_field_mask(input int unsigned reload_w);
    logic [31:0] m;
    m = '0;
    m[PRESCALE_BIT] = 1'b1;
    m[RUN_BIT]      = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i >= RELOAD_LSB && i < RELOAD_LSB + reload_w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Number of prescaled strobes between ticks for a reload value.
  function automatic int unsigned ticks_period(input int unsigned reload);
    return reload + 1;
  endfunction

endpackage

// File: rtl/baud_div_prescale.sv
module baud_div_prescale #(
  parameter int unsigned PRE_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic pre_sel,
  output logic stb
);

  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  generate
    if (PRE_DIV > 1) begin : g_div
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pre_q;
      logic          wrap;

      assign wrap = (pre_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_q <= '0;
        else if (restart)           pre_q <= '0;
        else if (!run || !pre_sel)  pre_q <= '0;
        else if (wrap)              pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
      end

      assign stb = run && (!pre_sel || wrap);

      // R5: with the prescale stage active, strobes are never back to back
      p_prescale_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && pre_sel && run && !restart) |=> !stb);
    end else begin : g_nodiv
      assign stb = run;
    end
  endgenerate

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_val,
  input  logic [CNT_W-1:0] reload,
  input  logic             run,
  input  logic             stb,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = (cnt_q == '0);
  assign tick   = run && stb && expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= restart_val;
    else if (tick)     cnt_q <= reload;
    else if (stb)      cnt_q <= cnt_q - 1'b1;
  end

  // R4: a stopped divider keeps its count
  p_hold_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q));

  // R10: non-zero reload never yields back-to-back ticks
  p_single_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && reload != '0) |=> !tick);

endmodule

// File: rtl/baud_div_square.sv
module baud_div_square (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic sq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sq <= 1'b0;
    else if (clr)   sq <= 1'b0;
    else if (tick)  sq <= ~sq;
  end

  // R8: each tick inverts the square output one cycle later
  p_toggle_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (sq != $past(sq)));

  // R8: no tick, no change
  p_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(sq));

endmodule

// File: rtl/baud_div_top.sv
module baud_div_top #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned PRE_DIV = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        tick_o,
  output logic        baud_o
);
  import baud_div_pkg::*;

  localparam logic [31:0] CFG_MASK = cfg_field_mask(CNT_W);

  logic [31:0]      cfg_q;
  logic             run_w;
  logic             pre_sel_w;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] new_reload_w;
  logic             pre_stb_w;
  logic             tick_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (cfg_we)  cfg_q <= cfg_wdata & CFG_MASK;
  end

  assign run_w        = cfg_q[RUN_BIT];
  assign pre_sel_w    = cfg_q[PRESCALE_BIT];
  assign reload_w     = cfg_q[RELOAD_LSB +: CNT_W];
  assign new_reload_w = cfg_wdata[RELOAD_LSB +: CNT_W];

  baud_div_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_we),
    .run     (run_w),
    .pre_sel (pre_sel_w),
    .stb     (pre_stb_w)
  );

  baud_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (cfg_we),
    .restart_val (new_reload_w),
    .reload      (reload_w),
    .run         (run_w),
    .stb         (pre_stb_w),
    .tick        (tick_w)
  );

  baud_div_square u_sq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_we),
    .tick  (tick_w),
    .sq    (baud_o)
  );

  assign tick_o    = tick_w;
  assign cfg_rdata = cfg_q;

  // R4: a stopped generator is idle
  p_idle_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |-> (!tick_o && !baud_o));

  // R9: a write restarts the square wave low
  p_restart_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !baud_o);

  // R2: undefined bits never read back as one
  p_undefined_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~CFG_MASK) == '0);

endmodule

// File: tb/baud_div_top_tb.sv
module baud_div_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam logic [31:0] RUN = 32'h0001_0000;
  localparam logic [31:0] PRE = 32'h0000_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tick_o;
  logic        baud_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int unsigned m_cfg = 0;
  int unsigned phase = 0;
  int unsigned nticks = 0;

  baud_div_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tick_o    (tick_o),
    .baud_o    (baud_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned word(input int unsigned reload);
    return reload * 2;
  endfunction

  function automatic bit model_tick();
    int unsigned per;
    if (((m_cfg >> 16) & 1) == 0) return 0;
    per = ((m_cfg >> 1) % 4096) + 1;
    if ((m_cfg & 1) != 0) per = per * 16;
    return ((phase + 1) % per) == 0;
  endfunction

  task automatic check1(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
               cur_req, what, act, exp, cycles);
    end
  endtask

  // Called at a falling edge: compare, drive, advance the model.
  task automatic step(input bit we, input logic [31:0] d);
    bit et;
    et = model_tick();
    check1("tick_o", int'(tick_o), int'(et));
    check1("baud_o", int'(baud_o), int'(nticks % 2));
    check1("cfg_rdata", int'(cfg_rdata), int'(m_cfg));
    cfg_we = we;
    cfg_wdata = d;
    if (we) begin
      m_cfg = d & 32'h0001_1FFF;
      phase = 0;
      nticks = 0;
    end else begin
      if (et) nticks++;
      phase++;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  task automatic wr(input logic [31:0] d);
    step(1'b1, d);
  endtask

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check1("reset tick_o", int'(tick_o), 0);
    check1("reset baud_o", int'(baud_o), 0);
    check1("reset cfg_rdata", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    run(3);

    cur_req = "R2";
    wr(32'hFFFF_FFFF);
    run(3);
    check1("R2 readback all ones", int'(cfg_rdata), 32'h0001_1FFF);
    wr(32'hFFFE_E000);
    run(3);

    cur_req = "R4";
    wr(word(3));
    run(20);

    cur_req = "R3";
    wr(RUN | word(4));
    run(40);

    cur_req = "R6";
    wr(RUN);
    run(10);
    wr(RUN | PRE);
    run(50);

    cur_req = "R5";
    wr(RUN | PRE | word(2));
    run(110);

    cur_req = "R9";
    wr(RUN | word(5));
    run(3);
    wr(RUN | word(1));
    run(10);
    wr(RUN | word(2));
    run(2);
    wr(RUN | word(2));
    run(12);

    cur_req = "R8";
    wr(RUN | word(2));
    run(24);

    cur_req = "R10";
    wr(RUN | word(1));
    run(12);

    cur_req = "R7";
    wr(RUN | word(4095));
    run(8200);

    cur_req = "R4";
    wr(RUN | word(3));
    run(5);
    wr(word(3));
    run(20);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule